// File: doc/BRIEF.md
# Bitmap Pixel Serializer with Span Fill

This block sits between the video memory fetch path and the colour outputs of a raster display. Each byte fetched for the screen carries two 4-bit pixels. The block unpacks them, high nibble first, and emits one pixel per pixel-clock enable on three digital colour lines (red, green, blue). It adds no intensity line. A single write-only control register, written by the CPU, sets the pixel mode, the TV timing standard flag and the RAM bank that screen fetches use.

Each pixel has a marker bit and three colour bits. In flash mode the marker makes the pixel blink: it alternates between its own colour and black on a slow phase derived from frame strobes. In span-fill mode the marker toggles a filled run on the current line. The pixel that opens the run fixes its colour. Every unmarked pixel after it shows that colour until a second marked pixel closes the run. A line-start strobe clears any open run. The fetch strobe is routed to one of two bank column strobes according to the bank bit.

Top module: `vid_pixel_serializer`

## Requirements
- R1: After reset the colour outputs are 000, the timing flag is 0, and a fetch strobe goes to bank strobe 0. The control register resets to 0.
- R2: A loaded byte gives two pixels, bits 7:4 first and then bits 3:0. The colour outputs change only on a clock edge where the pixel enable is high, one pixel per such edge, and otherwise hold their value.
- R3: For an unmarked pixel, nibble bit 2 drives red, bit 1 drives green and bit 0 drives blue.
- R4: The timing-standard output follows control bit 6 from the cycle after the write.
- R5: When control bit 7 is 0, the fetch strobe appears on bank strobe 0 only. When bit 7 is 1, it appears on bank strobe 1 only.
- R6: In flash mode (control bit 3 = 0), a marked pixel (nibble bit 3 = 1) shows its own colour while the blink phase is 0 and shows black while the phase is 1.
- R7: The blink phase starts at 0 and inverts on every 32nd frame strobe. It does not invert on any other strobe.
- R8: In fill mode (control bit 3 = 1), a marked pixel outside a run opens a run and shows its own colour. Unmarked pixels inside the run show the opening pixel's colour.
- R9: In fill mode, a marked pixel inside a run closes the run and shows its own colour. The unmarked pixels that follow show their own colours.
- R10: A line-start strobe closes any open run, so the next unmarked pixel shows its own colour.
- R11: In flash mode the marker never opens a run, so unmarked pixels that follow a marked one show their own colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Control register write strobe |
| cpu_wdata | input | 8 | Control register write data |
| fetch_valid | input | 1 | Loads a fetched screen byte |
| fetch_data | input | 8 | Fetched screen byte |
| fetch_strb | input | 1 | Video fetch column strobe request |
| pix_ce | input | 1 | Pixel clock enable |
| line_start | input | 1 | Start-of-line strobe |
| frame_strb | input | 1 | Start-of-frame strobe |
| bank_strb0 | output | 1 | Column strobe for bank 0 |
| bank_strb1 | output | 1 | Column strobe for bank 1 |
| ntsc_mode | output | 1 | Timing standard select |
| red | output | 1 | Red pixel output |
| green | output | 1 | Green pixel output |
| blue | output | 1 | Blue pixel output |

## Verification
The assertions assume that a byte load, a line start and a pixel enable never fall in the same cycle, and that a byte is loaded before its two pixels are taken. The stimulus loads each byte in a cycle of its own and then gives exactly two separate pixel enables. Line and frame strobes are always issued between bytes. The blink checks count frame strobes one at a time, so the pixel just before the 32nd strobe and the pixel just after it can both be compared.

// File: rtl/vps_pkg.sv
package vps_pkg;
  localparam int PIX_W         = 4;
  localparam int CTRL_W        = 8;
  localparam int CTRL_FILL_BIT = 3;
  localparam int CTRL_NTSC_BIT = 6;
  localparam int CTRL_BANK_BIT = 7;

  typedef logic [2:0] rgb_t;

  typedef struct packed {
    logic mark;
    rgb_t rgb;
  } pix_t;
endpackage

// File: rtl/vps_ctrl.sv
module vps_ctrl
  import vps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic              fill_mode_o,
  output logic              ntsc_o,
  output logic              bank_hi_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) ctrl_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign fill_mode_o = ctrl_q[CTRL_FILL_BIT];
  assign ntsc_o      = ctrl_q[CTRL_NTSC_BIT];
  assign bank_hi_o   = ctrl_q[CTRL_BANK_BIT];

  // R4
  ntsc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (ntsc_o == $past(wdata_i[CTRL_NTSC_BIT])));
endmodule

// File: rtl/vps_unpack.sv
module vps_unpack
  import vps_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              step_i,
  output pix_t              pix_o
);
  localparam int NPIX  = BYTE_W / PIX_W;
  localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1;

  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [PIX_W-1:0]  slot [NPIX];

  for (genvar g = 0; g < NPIX; g++) begin : g_slot
    assign slot[g] = byte_q[BYTE_W-1-g*PIX_W -: PIX_W];
  end

  always_comb begin
    byte_d = byte_q;
    idx_d  = idx_q;
    if (load_i) begin
      byte_d = data_i;
      idx_d  = '0;
    end else if (step_i) begin
      idx_d = (32'(idx_q) == NPIX-1) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      idx_q  <= '0;
    end else begin
      byte_q <= byte_d;
      idx_q  <= idx_d;
    end
  end

  assign pix_o = pix_t'(slot[idx_q]);

  // R2
  first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (pix_o == pix_t'($past(data_i[BYTE_W-1 -: PIX_W]))));
endmodule

// File: rtl/vps_blink.sv
module vps_blink #(
  parameter int FRAMES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_i,
  output logic blink_o
);
  localparam int CNT_W = (FRAMES > 1) ? $clog2(FRAMES) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             blink_q, blink_d;

  always_comb begin
    cnt_d   = cnt_q;
    blink_d = blink_q;
    if (frame_i) begin
      if (32'(cnt_q) == FRAMES-1) begin
        cnt_d   = '0;
        blink_d = ~blink_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blink_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      blink_q <= blink_d;
    end
  end

  assign blink_o = blink_q;

  // R7
  blink_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i |=> $stable(blink_o));
endmodule

// File: rtl/vps_colour.sv
module vps_colour
  import vps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pix_ce_i,
  input  logic line_start_i,
  input  logic fill_mode_i,
  input  logic blink_i,
  input  pix_t pix_i,
  output rgb_t rgb_o
);
  logic run_q, run_d;
  rgb_t run_rgb_q, run_rgb_d;
  rgb_t rgb_q, rgb_d;

  always_comb begin
    run_d     = run_q;
    run_rgb_d = run_rgb_q;
    rgb_d     = rgb_q;
    if (line_start_i) begin
      run_d = 1'b0;
    end else if (pix_ce_i) begin
      rgb_d = pix_i.rgb;
      if (fill_mode_i) begin
        if (pix_i.mark) begin
          run_d = ~run_q;
          if (!run_q) run_rgb_d = pix_i.rgb;
        end else if (run_q) begin
          rgb_d = run_rgb_q;
        end
      end else if (pix_i.mark && blink_i) begin
        rgb_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      run_rgb_q <= '0;
      rgb_q     <= '0;
    end else begin
      run_q     <= run_d;
      run_rgb_q <= run_rgb_d;
      rgb_q     <= rgb_d;
    end
  end

  assign rgb_o = rgb_q;

  // R2
  rgb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce_i |=> $stable(rgb_o));
  // R10
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_i |=> !run_q);
endmodule

// File: rtl/vid_pixel_serializer.sv
module vid_pixel_serializer
  import vps_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int FLASH_FRAMES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [CTRL_W-1:0] cpu_wdata,
  input  logic              fetch_valid,
  input  logic [BYTE_W-1:0] fetch_data,
  input  logic              fetch_strb,
  input  logic              pix_ce,
  input  logic              line_start,
  input  logic              frame_strb,
  output logic              bank_strb0,
  output logic              bank_strb1,
  output logic              ntsc_mode,
  output logic              red,
  output logic              green,
  output logic              blue
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       fill_mode, bank_hi, blink;
  pix_t       cur_pix;
  rgb_t       rgb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  vps_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .wr_i(cpu_wr), .wdata_i(cpu_wdata),
    .fill_mode_o(fill_mode), .ntsc_o(ntsc_mode), .bank_hi_o(bank_hi)
  );

  vps_unpack #(.BYTE_W(BYTE_W)) u_unpack (
    .clk(clk), .rst_n(rst_n_s), .load_i(fetch_valid), .data_i(fetch_data),
    .step_i(pix_ce), .pix_o(cur_pix)
  );

  vps_blink #(.FRAMES(FLASH_FRAMES)) u_blink (
    .clk(clk), .rst_n(rst_n_s), .frame_i(frame_strb), .blink_o(blink)
  );

  vps_colour u_colour (
    .clk(clk), .rst_n(rst_n_s), .pix_ce_i(pix_ce), .line_start_i(line_start),
    .fill_mode_i(fill_mode), .blink_i(blink), .pix_i(cur_pix), .rgb_o(rgb)
  );

  assign bank_strb0 = fetch_strb & ~bank_hi;
  assign bank_strb1 = fetch_strb &  bank_hi;
  assign red   = rgb[2];
  assign green = rgb[1];
  assign blue  = rgb[0];

  // R5
  bank_route_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    fetch_strb |-> ($countones({bank_strb0, bank_strb1}) == 1));
endmodule

// File: tb/test_vid_pixel_serializer.sv
module test_vid_pixel_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic       fetch_valid = 1'b0;
  logic [7:0] fetch_data = '0;
  logic       fetch_strb = 1'b0;
  logic       pix_ce = 1'b0;
  logic       line_start = 1'b0;
  logic       frame_strb = 1'b0;
  logic       bank_strb0, bank_strb1, ntsc_mode, red, green, blue;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  vid_pixel_serializer i_vid_pixel_serializer (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_strb(fetch_strb),
    .pix_ce(pix_ce), .line_start(line_start), .frame_strb(frame_strb),
    .bank_strb0(bank_strb0), .bank_strb1(bank_strb1), .ntsc_mode(ntsc_mode),
    .red(red), .green(green), .blue(blue)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pops one expected colour per pixel enable
  initial begin
    forever begin
      @(posedge clk);
      if (pix_ce) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk("queue", 1, 0);
        else chk(tag_q.pop_front(), int'({red, green, blue}), exp_q.pop_front());
      end
    end
  end

  task automatic wr_ctrl(input logic [7:0] v);
    cpu_wdata = v; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic load(input logic [7:0] b);
    fetch_data = b; fetch_valid = 1'b1;
    @(negedge clk); fetch_valid = 1'b0;
  endtask

  task automatic px(input int exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    pix_ce = 1'b1;
    @(negedge clk); pix_ce = 1'b0;
  endtask

  task automatic pulse_line();
    line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      frame_strb = 1'b1;
      @(negedge clk); frame_strb = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 rgb", int'({red, green, blue}), 0);
    chk("R1 ntsc", int'(ntsc_mode), 0);
    fetch_strb = 1'b1; #1;
    chk("R1 bank0", int'({bank_strb0, bank_strb1}), 2);
    fetch_strb = 1'b0;

    // R4: timing flag from bit 6
    wr_ctrl(8'h40);
    chk("R4 ntsc set", int'(ntsc_mode), 1);
    // R5: bit 7 moves fetches to bank 1
    wr_ctrl(8'h80);
    chk("R4 ntsc clear", int'(ntsc_mode), 0);
    fetch_strb = 1'b1; #1;
    chk("R5 bank1", int'({bank_strb0, bank_strb1}), 1);
    fetch_strb = 1'b0;
    wr_ctrl(8'h00);
    fetch_strb = 1'b1; #1;
    chk("R5 bank0", int'({bank_strb0, bank_strb1}), 2);
    fetch_strb = 1'b0;

    // R2: high nibble first, holds between enables
    load(8'h52);
    px(5, "R2 high");
    px(2, "R2 low");
    repeat (3) @(negedge clk);
    chk("R2 hold", int'({red, green, blue}), 2);

    // R3: bit mapping, colour 6 = red+green
    load(8'h61);
    px(6, "R3 first");
    chk("R3 red", int'(red), 1);
    chk("R3 blue", int'(blue), 0);
    px(1, "R3 second");
    chk("R3 blue only", int'({red, green, blue}), 1);

    // R6: flash mode, phase 0 shows own colour
    load(8'hB3);
    px(3, "R6 phase0 marked");
    px(3, "R11 unmarked after marker");

    // R7: no change after 31 strobes
    frames(31);
    load(8'hC4);
    px(4, "R7 before 32nd");
    px(4, "R7 plain");
    frames(1);
    load(8'hC4);
    px(0, "R6 phase1 marked black");
    px(4, "R6 unmarked unaffected");
    frames(32);
    load(8'hC4);
    px(4, "R7 second inversion");
    px(4, "R7 plain 2");

    // R11: flash mode never opens a run
    load(8'hD2);
    px(5, "R11 marker");
    px(2, "R11 own colour");

    // R8/R9: fill mode
    wr_ctrl(8'h08);
    pulse_line();
    load(8'hD2);
    px(5, "R8 open");
    px(5, "R8 inside");
    load(8'h37);
    px(5, "R8 inside 2");
    px(5, "R8 inside 3");
    load(8'h96);
    px(1, "R9 close");
    px(6, "R9 after");

    // R10: line start closes run
    load(8'hE0);
    px(6, "R10 open");
    px(6, "R10 inside");
    pulse_line();
    load(8'h12);
    px(1, "R10 after line");
    px(2, "R10 after line 2");

    repeat (4) @(negedge clk);
    chk("queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule